// File: doc/BRIEF.md
# Two-Level Occupancy Bitmap with Next-Occupied Search

This block records which of a fixed set of queue positions are occupied and finds the first occupied position at or after a given start. The positions are held as a row of detail words, one bit per position. A summary word holds one bit per detail word, and that bit is high exactly when its detail word is non-zero. A search always costs two word reads. The first read is the summary word together with the detail word that holds the start position. The second read is the single detail word that the summary selects.

A scheduler uses the block as follows. It raises the bit for a position when that position gains an entry and lowers it when the position drains. When it needs work, it asks for the next occupied position from its current pointer. The search runs forward only and never wraps past the last position. A position index is the detail-word number in the upper bits and the bit within the word in the lower bits. One update and one search may be issued in every cycle. The block applies no back-pressure: a request is always taken, and its result appears after a fixed delay with a one-cycle strobe that the consumer cannot stall.

Top module: `occ_bitmap_finder`

## Requirements
- R1: After reset every position is empty, `rsp_valid` and `rsp_found` are low, and a search from any start reports not-found.
- R2: An update with `upd_valid` high and `upd_set`=1 marks position `upd_idx`, where `upd_idx` = word*WORD_W + bit. A later search whose start is at or below that index and above every other occupied index returns it.
- R3: An update with `upd_set`=0 empties the position. When the last occupied position of a detail word is cleared, searches skip that whole word.
- R4: A search returns in `rsp_idx` the lowest occupied index greater than or equal to `req_start`, with `rsp_found`=1. When no such index exists it returns `rsp_found`=0 and `rsp_idx`=0. Indices below the start are never returned.
- R5: A request sampled in cycle t produces `rsp_valid` high in cycle t+2 for exactly one cycle. Requests may be issued in back-to-back cycles, and each one gets its own response in order.
- R6: An update issued in the same cycle as a search is seen by that search. A set below the start index therefore leaves the result unchanged, and a set or clear at or after the start is reflected in it.
- R7: Updates issued in the cycle after a request do not change that request's result.
- R8: On every cycle each summary bit equals the OR of the bits of its detail word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Apply an update this cycle |
| upd_set | input | 1 | 1 = mark the position occupied, 0 = mark it empty |
| upd_idx | input | IDX_W | Position to update |
| req_valid | input | 1 | Start a search this cycle |
| req_start | input | IDX_W | First position the search may return |
| rsp_valid | output | 1 | Search result strobe |
| rsp_found | output | 1 | An occupied position was found |
| rsp_idx | output | IDX_W | Found position, or 0 when not found |

## Verification
The bound checker watches, on every cycle, that the summary bits agree with their detail words and that the response strobe trails the request by exactly two cycles. On each response it checks that a returned index lies at or above the start, points at an occupied position, and is zero on not-found. It also checks that set and clear take effect on the next cycle. Two things can only be shown by the bench's scenarios: that the returned index is the lowest qualifying one, and the exact visibility of updates in the request cycle and the cycle after it. To show these, the bench sweeps every start position against a reference bitmap, for every single-bit pattern and for mixed patterns.

// File: rtl/occ_bitmap_pkg.sv
package occ_bitmap_pkg;
  typedef enum logic {
    OCC_CLEAR = 1'b0,
    OCC_SET   = 1'b1
  } occ_op_e;
endpackage

// File: rtl/occ_lowbit_enc.sv
module occ_lowbit_enc #(
  parameter int W = 32,
  localparam int POS_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             any,
  output logic [POS_W-1:0] pos
);
  always_comb begin
    any = |vec;
    pos = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) pos = POS_W'(i);
    end
  end
endmodule

// File: rtl/occ_bitmap_store.sv
module occ_bitmap_store
  import occ_bitmap_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 32,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int WRD_W = $clog2(N_WORDS),
  localparam int IDX_W = BIT_W + WRD_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            upd_valid,
  input  logic                            upd_set,
  input  logic [IDX_W-1:0]                upd_idx,
  output logic [N_WORDS-1:0][WORD_W-1:0]  det_q,
  output logic [N_WORDS-1:0]              sum_q,
  output logic [N_WORDS-1:0][WORD_W-1:0]  det_nxt,
  output logic [N_WORDS-1:0]              sum_nxt
);
  logic [WRD_W-1:0] uw;
  logic [BIT_W-1:0] ub;

  assign uw = upd_idx[IDX_W-1:BIT_W];
  assign ub = upd_idx[BIT_W-1:0];

  // Next state of both levels; the summary bit of the touched word alone moves.
  always_comb begin
    det_nxt = det_q;
    sum_nxt = sum_q;
    if (upd_valid) begin
      if (occ_op_e'(upd_set) == OCC_SET) begin
        det_nxt[uw][ub] = 1'b1;
        sum_nxt[uw]     = 1'b1;
      end else begin
        det_nxt[uw][ub] = 1'b0;
        sum_nxt[uw]     = |(det_q[uw] & ~(WORD_W'(1) << ub));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_q <= '0;
      sum_q <= '0;
    end else begin
      det_q <= det_nxt;
      sum_q <= sum_nxt;
    end
  end
endmodule

// File: rtl/occ_search_pipe.sv
module occ_search_pipe #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 32,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int WRD_W = $clog2(N_WORDS),
  localparam int IDX_W = BIT_W + WRD_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [IDX_W-1:0]                req_start,
  input  logic [N_WORDS-1:0][WORD_W-1:0]  det_q,
  input  logic [N_WORDS-1:0][WORD_W-1:0]  det_nxt,
  input  logic [N_WORDS-1:0]              sum_nxt,
  output logic                            rsp_valid,
  output logic                            rsp_found,
  output logic [IDX_W-1:0]                rsp_idx
);
  // Stage A: summary read plus the start word, both taken from post-update state.
  logic [WRD_W-1:0]   sw;
  logic [BIT_W-1:0]   so;
  logic [WORD_W-1:0]  start_word;
  logic [N_WORDS-1:0] sum_above;
  logic               a_hit;
  logic [BIT_W-1:0]   a_pos;
  logic               s_any;
  logic [WRD_W-1:0]   s_pos;

  assign sw         = req_start[IDX_W-1:BIT_W];
  assign so         = req_start[BIT_W-1:0];
  assign start_word = det_nxt[sw] & ~((WORD_W'(1) << so) - WORD_W'(1));
  assign sum_above  = sum_nxt & ~((N_WORDS'(2) << sw) - N_WORDS'(1));

  occ_lowbit_enc #(.W(WORD_W))  u_enc_start (.vec(start_word), .any(a_hit), .pos(a_pos));
  occ_lowbit_enc #(.W(N_WORDS)) u_enc_sum   (.vec(sum_above),  .any(s_any), .pos(s_pos));

  logic             a_v_q;
  logic             a_hit_q;
  logic [IDX_W-1:0] a_idx_q;
  logic             s_any_q;
  logic [WRD_W-1:0] s_word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_v_q    <= 1'b0;
      a_hit_q  <= 1'b0;
      a_idx_q  <= '0;
      s_any_q  <= 1'b0;
      s_word_q <= '0;
    end else begin
      a_v_q    <= req_valid;
      a_hit_q  <= a_hit;
      a_idx_q  <= {sw, a_pos};
      s_any_q  <= s_any;
      s_word_q <= s_pos;
    end
  end

  // Stage B: one detail-word read; det_q now holds the request-cycle state.
  logic [WORD_W-1:0] b_word;
  logic              b_any;
  logic [BIT_W-1:0]  b_pos;

  assign b_word = det_q[s_word_q];

  occ_lowbit_enc #(.W(WORD_W)) u_enc_det (.vec(b_word), .any(b_any), .pos(b_pos));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= a_v_q;
      rsp_found <= 1'b0;
      rsp_idx   <= '0;
      if (a_v_q) begin
        if (a_hit_q) begin
          rsp_found <= 1'b1;
          rsp_idx   <= a_idx_q;
        end else if (s_any_q && b_any) begin
          rsp_found <= 1'b1;
          rsp_idx   <= {s_word_q, b_pos};
        end
      end
    end
  end
endmodule

// File: rtl/occ_bitmap_finder.sv
module occ_bitmap_finder #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 32,
  localparam int IDX_W = $clog2(WORD_W) + $clog2(N_WORDS),
  localparam int TOT   = WORD_W * N_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic             upd_set,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_start,
  output logic             rsp_valid,
  output logic             rsp_found,
  output logic [IDX_W-1:0] rsp_idx
);
  logic [N_WORDS-1:0][WORD_W-1:0] det_q;
  logic [N_WORDS-1:0][WORD_W-1:0] det_nxt;
  logic [N_WORDS-1:0]             sum_q;
  logic [N_WORDS-1:0]             sum_nxt;
  logic [TOT-1:0]                 det_flat;

  assign det_flat = det_q;

  occ_bitmap_store #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_set(upd_set), .upd_idx(upd_idx),
    .det_q(det_q), .sum_q(sum_q), .det_nxt(det_nxt), .sum_nxt(sum_nxt)
  );

  occ_search_pipe #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_search (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_start(req_start),
    .det_q(det_q), .det_nxt(det_nxt), .sum_nxt(sum_nxt),
    .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_idx(rsp_idx)
  );
endmodule

// File: rtl/occ_bitmap_finder_chk.sv
module occ_bitmap_finder_chk #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 32,
  localparam int IDX_W = $clog2(WORD_W) + $clog2(N_WORDS),
  localparam int TOT   = WORD_W * N_WORDS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_valid,
  input logic               upd_set,
  input logic [IDX_W-1:0]   upd_idx,
  input logic               req_valid,
  input logic [IDX_W-1:0]   req_start,
  input logic               rsp_valid,
  input logic               rsp_found,
  input logic [IDX_W-1:0]   rsp_idx,
  input logic [TOT-1:0]     det_flat,
  input logic [N_WORDS-1:0] sum_q
);
  logic [TOT-1:0] det_d;
  always_ff @(posedge clk) det_d <= det_flat;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_sum
    // R8
    sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sum_q[w] == |det_flat[w*WORD_W +: WORD_W]);
  end

  // R5
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid, 2));

  // R4
  rsp_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_found) |-> (rsp_idx >= $past(req_start, 2)));

  // R4
  rsp_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_found) |-> det_d[rsp_idx]);

  // R4
  nf_zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_found) |-> (rsp_idx == '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_found);

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_set) |=> det_flat[$past(upd_idx)]);

  // R3
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_set) |=> !det_flat[$past(upd_idx)]);
endmodule

bind occ_bitmap_finder occ_bitmap_finder_chk #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .upd_valid(upd_valid), .upd_set(upd_set), .upd_idx(upd_idx),
  .req_valid(req_valid), .req_start(req_start),
  .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_idx(rsp_idx),
  .det_flat(det_flat), .sum_q(sum_q)
);

// File: tb/occ_bitmap_finder_tb.sv
module occ_bitmap_finder_tb;
  localparam int WW  = 8;
  localparam int NW  = 4;
  localparam int TOT = WW * NW;
  localparam int IW  = $clog2(TOT);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd_valid = 1'b0;
  logic          upd_set = 1'b0;
  logic [IW-1:0] upd_idx = '0;
  logic          req_valid = 1'b0;
  logic [IW-1:0] req_start = '0;
  logic          rsp_valid;
  logic          rsp_found;
  logic [IW-1:0] rsp_idx;

  int n_chk = 0;
  int n_err = 0;
  logic [TOT-1:0] occ = '0;

  always #10 clk = ~clk;

  occ_bitmap_finder #(.WORD_W(WW), .N_WORDS(NW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_set(upd_set), .upd_idx(upd_idx),
    .req_valid(req_valid), .req_start(req_start),
    .rsp_valid(rsp_valid), .rsp_found(rsp_found), .rsp_idx(rsp_idx)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  // Expected search result: -1 encodes not-found.
  function automatic int ref_find(input logic [TOT-1:0] st, input int s);
    for (int i = s; i < TOT; i++) if (st[i]) return i;
    return -1;
  endfunction

  function automatic int got();
    return rsp_found ? int'(rsp_idx) : ((rsp_idx == '0) ? -1 : -2);
  endfunction

  task automatic upd(input bit s, input int i);
    upd_valid = 1'b1; upd_set = s; upd_idx = IW'(i);
    @(negedge clk);
    upd_valid = 1'b0;
    occ[i] = s;
  endtask

  // Single search, optionally with an update in the request cycle (same)
  // or in the cycle after it (late).
  task automatic find(input int s, input bit same, input bit late,
                      input bit us, input int ui, input string rq);
    int e;
    req_valid = 1'b1; req_start = IW'(s);
    if (same) begin
      upd_valid = 1'b1; upd_set = us; upd_idx = IW'(ui); occ[ui] = us;
    end
    e = ref_find(occ, s);
    @(negedge clk);
    req_valid = 1'b0; upd_valid = 1'b0;
    if (late) begin
      upd_valid = 1'b1; upd_set = us; upd_idx = IW'(ui); occ[ui] = us;
    end
    chk(rsp_valid == 1'b0, "R5 early strobe", rsp_valid, 0);
    @(negedge clk);
    upd_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R5 strobe", rsp_valid, 1);
    chk(got() == e, rq, got(), e);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R5 single pulse", rsp_valid, 0);
  endtask

  // Back-to-back searches from every start; the bitmap is held constant.
  task automatic sweep(input string rq);
    for (int c = 0; c < TOT + 2; c++) begin
      if (c >= 2) begin
        chk(rsp_valid == 1'b1, "R5 pipelined strobe", rsp_valid, 1);
        chk(got() == ref_find(occ, c - 2), rq, got(), ref_find(occ, c - 2));
      end
      req_valid = (c < TOT);
      req_start = IW'(c);
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_found == 1'b0, "R1 reset outputs", rsp_valid, 0);
    sweep("R1 R4 empty after reset");

    // R2 R4: every single occupied position against every start
    for (int p = 0; p < TOT; p++) begin
      upd(1'b1, p);
      sweep("R2 R4 single position");
      upd(1'b0, p);
    end

    // R4 mixed pattern
    for (int p = 0; p < TOT; p++) if ((p % 5) == 2 || p == 31) upd(1'b1, p);
    sweep("R4 mixed pattern");

    // R3: drain word 1 (positions 8..15) and search from its base
    for (int p = 8; p < 16; p++) if (occ[p]) upd(1'b0, p);
    find(8, 0, 0, 0, 0, "R3 emptied word skipped");
    sweep("R3 after word drain");
    for (int p = 0; p < TOT; p++) if (occ[p]) upd(1'b0, p);
    find(0, 0, 0, 0, 0, "R3 all cleared");

    // R6: same-cycle updates
    find(10, 1, 0, 1, 12, "R6 same-cycle set after start");
    upd(1'b1, 30);
    find(10, 1, 0, 1, 5, "R6 same-cycle set below start");
    find(10, 1, 0, 0, 12, "R6 same-cycle clear after start");
    find(10, 1, 0, 1, 10, "R6 same-cycle set at start");

    // R7: updates in the cycle after the request
    for (int p = 0; p < TOT; p++) if (occ[p]) upd(1'b0, p);
    upd(1'b1, 20);
    begin
      int keep;
      keep = ref_find(occ, 0);
      find(0, 0, 1, 0, 20, "R7 late clear ignored (pre)");
    end
    find(0, 0, 0, 0, 0, "R7 late clear then applies");
    find(0, 0, 1, 1, 3, "R7 late set ignored");
    find(0, 0, 0, 0, 0, "R7 late set then applies");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule